// File: doc/BRIEF.md
# Programmable Flash Read Stall Controller

This block sits between a processor's instruction/data read port and a slow synchronous flash array. A read request carries an address. The controller latches that address and drives it to the array. It then keeps its ready output low for a programmed number of stall cycles. After that it passes the array's data through and raises ready for exactly one cycle.

The stall count runs from 0 to 3 and lives in a small configuration register. Software sets it to match the core clock, so that the time the array gets to settle stays at about 33 ns whatever the clock speed. A combinational helper suggests a count from the clock frequency in MHz: the frequency divided by 30, rounded down and capped at the largest count. A larger count makes each access longer but never changes the data returned.

Each access takes its stall count from the register at the moment the request is accepted. A new request can be accepted in the same cycle that the previous one completes, so no idle cycle is needed between accesses.

Top module: `flash_wait_ctrl`

## Requirements
- R1: During and right after reset, `busy` and `rsp_ready` are low, `rsp_data` is zero and `cfg_wait` reads 3, the slowest setting.
- R2: When `cfg_we` is high at a clock edge, `cfg_wait` shows `cfg_wdata` (2 bits, value = stall cycles) from the next cycle onward. Otherwise it holds its value.
- R3: A request is accepted at a clock edge where `req_valid` is high and either `busy` is low or `rsp_ready` is high. From the next cycle `fl_addr` equals the accepted address, and it holds stable until the next acceptance.
- R4: For an access accepted with stall count w, `rsp_ready` is low in the w cycles that follow the accepting edge. It is high in the cycle after those (cycle index w, counting the first cycle as 0), and only in that cycle.
- R5: `rsp_data` equals `fl_rdata` while `rsp_ready` is high and is zero otherwise.
- R6: A write to the stall register during an access does not change that access's length. The new value governs only requests accepted after the write.
- R7: If `req_valid` is high in a `rsp_ready` cycle, the next access begins at once: `busy` stays high and the new address appears on `fl_addr` in the following cycle.
- R8: `rec_wait` equals the smaller of 3 and floor(`clk_mhz` / 30).
- R9: `busy` and `fl_rd` are high from the cycle after an acceptance through the `rsp_ready` cycle. They are low when no access is in progress.
- R10: Against an array that needs its address held for two cycles before its output is valid, stall counts 0 and 1 return wrong data and counts 2 and 3 return the correct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the stall register |
| cfg_wdata | input | 2 | New stall count |
| cfg_wait | output | 2 | Current stall count |
| clk_mhz | input | 10 | Core clock frequency in MHz for the helper |
| rec_wait | output | 2 | Suggested stall count for `clk_mhz` |
| req_valid | input | 1 | Read request from the processor |
| req_addr | input | 16 | Read address |
| busy | output | 1 | An access is in progress |
| rsp_ready | output | 1 | Read data is valid this cycle |
| rsp_data | output | 32 | Read data, zero when not ready |
| fl_rd | output | 1 | Read enable to the array |
| fl_addr | output | 16 | Address held on the array |
| fl_rdata | input | 32 | Array output |

## Verification
The checker rebuilds the expected ready cycle from the ports alone. It latches the stall count at each acceptance and counts cycles from there. This relies on acceptance being visible purely from `req_valid`, `busy` and `rsp_ready`, and on `req_valid` never being unknown after reset. The bench drives every input on the falling edge. It writes the stall register only while idle or deliberately in mid-access for R6, and it never issues two consecutive requests to the same address. That last rule keeps the array model's settle timer meaningful.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } fwc_phase_e;

  // Suggested stall count: floor(mhz / step), saturated at cap.
  function automatic int unsigned wait_for_mhz(input int unsigned mhz,
                                               input int unsigned step,
                                               input int unsigned cap);
    int unsigned q;
    q = (step == 0) ? cap : mhz / step;
    return (q > cap) ? cap : q;
  endfunction

  // True when a request is taken at this edge.
  function automatic logic take_req(input logic valid, input logic busy_now,
                                    input logic done_now);
    return valid && (!busy_now || done_now);
  endfunction

endpackage

// File: rtl/fwc_cfg.sv
module fwc_cfg #(
  parameter int WW       = 2,
  parameter int FW       = 10,
  parameter int STEP_MHZ = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [WW-1:0] wdata,
  input  logic [FW-1:0] clk_mhz,
  output logic [WW-1:0] wait_q,
  output logic [WW-1:0] rec
);
  import fwc_pkg::*;
  localparam int unsigned MAXW = (1 << WW) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)   wait_q <= WW'(MAXW);
    else if (we)  wait_q <= wdata;
  end

  always_comb begin
    int unsigned r;
    r   = wait_for_mhz(int'(clk_mhz), STEP_MHZ, MAXW);
    rec = WW'(r);
  end
endmodule

// File: rtl/fwc_stall.sv
module fwc_stall #(
  parameter int WW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [WW-1:0] wait_in,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output fwc_pkg::fwc_phase_e phase
);
  import fwc_pkg::*;
  logic [WW-1:0] cnt_q;
  logic          busy_q;

  assign busy   = busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign accept = take_req(req_valid, busy_q, done);
  assign phase  = !busy_q ? ST_IDLE : (done ? ST_DONE : ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_in;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - WW'(1);
    end
  end
endmodule

// File: rtl/fwc_path.sv
module fwc_path #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          done,
  input  logic [DW-1:0] fl_rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] rsp_data
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign fl_addr  = addr_q;
  assign rsp_data = done ? fl_rdata : '0;
endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int WW       = 2,
  parameter int FW       = 10,
  parameter int STEP_MHZ = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [WW-1:0] cfg_wdata,
  output logic [WW-1:0] cfg_wait,
  input  logic [FW-1:0] clk_mhz,
  output logic [WW-1:0] rec_wait,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_rdata
);
  logic                accept_w;
  logic                done_w;
  logic                busy_w;
  fwc_pkg::fwc_phase_e phase_w;

  fwc_cfg #(.WW(WW), .FW(FW), .STEP_MHZ(STEP_MHZ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .clk_mhz(clk_mhz), .wait_q(cfg_wait), .rec(rec_wait)
  );

  fwc_stall #(.WW(WW)) u_stall (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wait_in(cfg_wait),
    .accept(accept_w), .busy(busy_w), .done(done_w), .phase(phase_w)
  );

  fwc_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .req_addr(req_addr),
    .done(done_w), .fl_rdata(fl_rdata), .fl_addr(fl_addr), .rsp_data(rsp_data)
  );

  assign busy      = busy_w;
  assign fl_rd     = busy_w;
  assign rsp_ready = done_w;
endmodule

// File: rtl/fwc_checker.sv
module fwc_checker #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int WW       = 2,
  parameter int FW       = 10,
  parameter int STEP_MHZ = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [DW-1:0] fl_rdata,
  input logic [AW-1:0] fl_addr,
  input logic          fl_rd,
  input logic [WW-1:0] cfg_wait,
  input logic [FW-1:0] clk_mhz,
  input logic [WW-1:0] rec_wait,
  input logic          accept_w
);
  logic          act;
  logic [WW-1:0] lat_w;
  logic [WW-1:0] age;
  logic          seen_acc;

  assign seen_acc = req_valid && (!busy || rsp_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; lat_w <= '0; age <= '0;
    end else if (seen_acc) begin
      act <= 1'b1; lat_w <= cfg_wait; age <= '0;
    end else if (rsp_ready) begin
      act <= 1'b0;
    end else if (act) begin
      age <= age + WW'(1);
    end
  end

  assert_ready_on_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && age == lat_w) |-> rsp_ready);
  assert_no_early_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (act && age == lat_w));
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_ready) |=> $stable(fl_addr));
  assert_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> (rsp_data == '0));
  assert_data_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (rsp_data == fl_rdata));
  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && req_valid) |=> busy);
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_rd) |-> $past(accept_w));
  assert_slow_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(clk_mhz) < STEP_MHZ) |-> (rec_wait == '0));
endmodule

bind flash_wait_ctrl fwc_checker #(
  .AW(AW), .DW(DW), .WW(WW), .FW(FW), .STEP_MHZ(STEP_MHZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fl_rdata(fl_rdata),
  .fl_addr(fl_addr), .fl_rd(fl_rd), .cfg_wait(cfg_wait), .clk_mhz(clk_mhz),
  .rec_wait(rec_wait), .accept_w(accept_w)
);

// File: tb/sim_flash_wait_ctrl.sv
module sim_flash_wait_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NEED = 2;   // cycles the array needs the address held
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_wait;
  logic [9:0] clk_mhz = 10'd125;
  logic [1:0] rec_wait;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, rsp_ready, fl_rd;
  logic [DW-1:0] rsp_data, fl_rdata;
  logic [AW-1:0] fl_addr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  flash_wait_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_wait(cfg_wait), .clk_mhz(clk_mhz), .rec_wait(rec_wait),
    .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fl_rd(fl_rd),
    .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  // Array model: correct word only once the address has been held NEED cycles.
  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h1234_5678;
  endfunction
  function automatic logic [DW-1:0] junk_at(input logic [AW-1:0] a);
    return word_at(a) ^ 32'hDEAD_BEEF;
  endfunction

  logic [AW-1:0] last_addr = '0;
  int run = 0;
  int held;
  always @(posedge clk) begin
    run <= (fl_addr != last_addr) ? 1 : ((run < 15) ? run + 1 : run);
    last_addr <= fl_addr;
  end
  always_comb begin
    held = (fl_addr != last_addr) ? 0 : run;
    fl_rdata = (held >= NEED) ? word_at(fl_addr) : junk_at(fl_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_wait(input logic [1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_access(input logic [AW-1:0] a, output logic [DW-1:0] d,
                            output int lat);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0; lat = 0;
    while (!rsp_ready && lat < 10) begin @(negedge clk); lat++; end
    d = rsp_data;
  endtask

  // {wait, addr}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'h0011}, {2'd1, 16'h0022}, {2'd2, 16'h0033}, {2'd3, 16'h0044},
    {2'd3, 16'hBEEF}, {2'd2, 16'h1234}, {2'd1, 16'h8001}, {2'd0, 16'h7FFE}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;
    int lat;
    int cyc;
    bit ok;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && rsp_ready == 0, "R1 idle", {30'd0, busy, rsp_ready}, 0);
    chk(cfg_wait == 2'd3, "R1 cfg", 32'(cfg_wait), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_data == '0 && fl_rd == 0, "R1 after", rsp_data, 0);

    // R2 register write
    set_wait(2'd1);
    chk(cfg_wait == 2'd1, "R2 write", 32'(cfg_wait), 1);
    @(negedge clk);
    chk(cfg_wait == 2'd1, "R2 hold", 32'(cfg_wait), 1);

    // Vector table: R4 latency, R5/R10 data
    for (int i = 0; i < NV; i++) begin
      logic [1:0] w;
      logic [AW-1:0] a;
      logic [DW-1:0] exp;
      w = VEC[i][17:16]; a = VEC[i][15:0];
      set_wait(w);
      run_access(a, d, lat);
      chk(lat == int'(w), "R4 stall length", 32'(lat), 32'(w));
      exp = (int'(w) >= NEED) ? word_at(a) : junk_at(a);
      chk(d == exp, "R10 data vs stall", d, exp);
      chk(fl_addr == a, "R3 addr", 32'(fl_addr), 32'(a));
      @(negedge clk);
      chk(rsp_ready == 0 && rsp_data == '0 && busy == 0, "R5 R9 after",
          rsp_data, 0);
    end

    // R6: rewrite during an access
    set_wait(2'd3);
    @(negedge clk); req_valid = 1'b1; req_addr = 16'h0A0A;
    @(negedge clk); req_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = 2'd0;
    lat = 0;
    @(negedge clk); cfg_we = 1'b0; lat = 1;
    while (!rsp_ready && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == 3, "R6 old count kept", 32'(lat), 3);
    run_access(16'h0B0B, d, lat);
    chk(lat == 0, "R6 new count used", 32'(lat), 0);

    // R7: back-to-back with stall 2
    set_wait(2'd2);
    @(negedge clk); req_valid = 1'b1; req_addr = 16'h0C0C;
    @(negedge clk); req_addr = 16'h0D0D; cyc = 0; ok = 1;
    while (!rsp_ready && cyc < 10) begin
      @(negedge clk); cyc++; ok &= busy;
    end
    chk(cyc == 2 && rsp_data == word_at(16'h0C0C), "R7 first", rsp_data,
        word_at(16'h0C0C));
    @(negedge clk); req_valid = 1'b0;
    chk(busy == 1 && fl_addr == 16'h0D0D, "R7 no gap", 32'(fl_addr), 32'h0D0D);
    cyc = 0;
    while (!rsp_ready && cyc < 10) begin
      @(negedge clk); cyc++; ok &= busy;
    end
    chk(cyc == 2 && ok && rsp_data == word_at(16'h0D0D), "R7 second",
        rsp_data, word_at(16'h0D0D));
    chk(fl_rd == 1, "R9 rd in ready", 32'(fl_rd), 1);

    // R8 helper
    for (int f = 0; f < 1024; f += 7) begin
      int e;
      clk_mhz = 10'(f);
      #1;
      e = (f / 30 > 3) ? 3 : f / 30;
      chk(int'(rec_wait) == e, "R8 helper", 32'(rec_wait), 32'(e));
    end
    clk_mhz = 10'd125; #1;
    chk(rec_wait == 2'd3, "R8 125MHz", 32'(rec_wait), 3);
    clk_mhz = 10'd60; #1;
    chk(rec_wait == 2'd2, "R8 60MHz", 32'(rec_wait), 2);
    clk_mhz = 10'd29; #1;
    chk(rec_wait == 2'd0, "R8 29MHz", 32'(rec_wait), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule